// File: doc/BRIEF.md
# Extended Address Register File

This block keeps a bank of 32 extended registers, 64 bits each. Each one holds the upper half of a wide memory address and pairs with the base integer register that has the same 5-bit index. A load/store address generator reads two upper halves at a time through two combinational read ports. For each port the block reports whether the index falls in the low group (indices 0 to 9), which may never be used to form an address.

The extended registers are reached only through three add-immediate move operations. Each one adds a sign-extended 12-bit immediate to a source value and writes the sum. The moves are: extended to base, base to extended, and extended to extended. The instruction decoder sits outside and supplies the raw instruction word and a two-bit operation kind. The base register value arrives as an operand, and base-register results leave the block as a write request. A separate write port takes 64-bit load results from context-restore operations.

Top module: `xaddr_regfile`

## Requirements
- R1: Synchronous active-low reset clears every extended register to zero.
- R2: Kind 2'b01 (extended to base), with `mv_valid` high, drives `base_wr_en` high, `base_wr_idx` = rd and `base_wr_data` = ext[rs1] + sext(imm) in the same cycle, and leaves every extended register unchanged.
- R3: Kind 2'b10 (base to extended) writes ext[rd] = `mv_base_val` + sext(imm) at the next rising edge.
- R4: Kind 2'b11 (extended to extended) writes ext[rd] = ext[rs1] + sext(imm) at the next rising edge, and rd may equal rs1.
- R5: The 12-bit immediate is sign-extended to 64 bits: 0x000 gives a plain move and 0xFFF subtracts one.
- R6: Sums wrap modulo 2^64 and no overflow indication exists.
- R7: Fields come from `mv_instr`: imm in bits 31:20, rs1 in bits 19:15, rd in bits 11:7. Bits 14:12 and 6:0 are ignored.
- R8: `ld_we` writes `ld_data` into ext[`ld_idx`] at the next rising edge.
- R9: A read index below 10 raises that port's reserved flag combinationally and forces its data to zero. Index 10 and above read normally with the flag low.
- R10: A read in the same cycle as a write to that index returns the old value. The new value appears after the edge.
- R11: When a move and a load write the same extended register in one cycle, the move result is kept.
- R12: With `mv_valid` low, or with kind 2'b00, no register changes and `base_wr_en` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mv_valid | input | 1 | Move operation present this cycle |
| mv_kind | input | 2 | 00 none, 01 ext to base, 10 base to ext, 11 ext to ext |
| mv_instr | input | 32 | Raw instruction word of the move |
| mv_base_val | input | 64 | Base register operand for kind 10 |
| base_wr_en | output | 1 | Base register write request |
| base_wr_idx | output | 5 | Base register target index |
| base_wr_data | output | 64 | Base register write value |
| ld_we | input | 1 | Context-restore load write enable |
| ld_idx | input | 5 | Load target extended index |
| ld_data | input | 64 | Load result |
| rd_idx_a | input | 5 | Read port A index |
| rd_data_a | output | 64 | Read port A upper address half |
| rd_rsv_a | output | 1 | Port A index is reserved |
| rd_idx_b | input | 5 | Read port B index |
| rd_data_b | output | 64 | Read port B upper address half |
| rd_rsv_b | output | 1 | Port B index is reserved |

## Verification
The assertions assume that inputs change only between clock edges. They also assume that a read port's index is free to change in any cycle. So the stability check compares data only when the index has held steady and no write landed on the bank. The load-follow check assumes no move targets the same register in that cycle. The stimulus drives every input just after the falling edge. It holds read indices steady across the edges it inspects, and it drives a colliding move and load only in the dedicated conflict scenario, where the load-follow property excuses itself.

// File: rtl/xaddr_pkg.sv
// Package: shared kinds and field positions for the extended address register file.
// Assumes a 32-bit I-type instruction word.
package xaddr_pkg;
    typedef enum logic [1:0] {
        MV_NONE = 2'b00,
        MV_E2B  = 2'b01,
        MV_B2E  = 2'b10,
        MV_E2E  = 2'b11
    } mv_kind_e;

    localparam int IMM_LSB = 20;
    localparam int RS1_LSB = 15;
    localparam int RD_LSB  = 7;
endpackage

// File: rtl/xaddr_addimm.sv
// Module: sign-extends an immediate and adds it to a source operand.
// Assumes IMMW < XLEN; the sum wraps and carries are discarded.
module xaddr_addimm #(
    parameter int XLEN = 64,
    parameter int IMMW = 12
) (
    input  logic [XLEN-1:0] src_i,
    input  logic [IMMW-1:0] imm_i,
    output logic [XLEN-1:0] sum_o
);
    localparam int PADW = XLEN - IMMW;

    logic [XLEN-1:0] imm_sx;

    // Replicate the immediate sign bit up to the full width.
    always_comb imm_sx = {{PADW{imm_i[IMMW-1]}}, imm_i};

    // Wrapping add, no overflow output.
    always_comb sum_o = src_i + imm_sx;
endmodule

// File: rtl/xaddr_bank.sv
// Module: storage for the extended registers with a move port and a load port.
// Assumes the move port outranks the load port when both hit one entry.
module xaddr_bank #(
    parameter int XLEN = 64,
    parameter int NREG = 32,
    localparam int IDXW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mv_we_i,
    input  logic [IDXW-1:0] mv_idx_i,
    input  logic [XLEN-1:0] mv_data_i,
    input  logic            ld_we_i,
    input  logic [IDXW-1:0] ld_idx_i,
    input  logic [XLEN-1:0] ld_data_i,
    output logic [XLEN-1:0] q_o [NREG]
);
    for (genvar g = 0; g < NREG; g++) begin : g_ent
        // One entry: reset to zero, move write first, load write second.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q_o[g] <= '0;
            else if (mv_we_i && mv_idx_i == IDXW'(g))
                q_o[g] <= mv_data_i;
            else if (ld_we_i && ld_idx_i == IDXW'(g))
                q_o[g] <= ld_data_i;
        end
    end

    AST_MV_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mv_we_i |=> q_o[$past(mv_idx_i)] == $past(mv_data_i)); // R3
    AST_LD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_we_i && !(mv_we_i && mv_idx_i == ld_idx_i)) |=> q_o[$past(ld_idx_i)] == $past(ld_data_i)); // R8
endmodule

// File: rtl/xaddr_rdport.sv
// Module: one address read port with reserved-index detection.
// Assumes indices below RSV_LIMIT must never yield an address.
module xaddr_rdport #(
    parameter int XLEN      = 64,
    parameter int NREG      = 32,
    parameter int RSV_LIMIT = 10,
    localparam int IDXW     = $clog2(NREG)
) (
    input  logic [XLEN-1:0] regs_i [NREG],
    input  logic [IDXW-1:0] idx_i,
    output logic [XLEN-1:0] data_o,
    output logic            rsv_o
);
    // Flag the low reserved group.
    always_comb rsv_o = (32'(idx_i) < RSV_LIMIT);

    // Zero the data when the index is reserved.
    always_comb data_o = rsv_o ? '0 : regs_i[idx_i];
endmodule

// File: rtl/xaddr_regfile.sv
// Module: extended address register file top. It executes the three add-immediate
// moves, serves two address read ports and accepts context-restore loads.
// Assumes an external decoder supplies mv_kind. Ext writes land at the next edge,
// base writes leave combinationally, and reads have no bypass.
module xaddr_regfile #(
    parameter int XLEN      = 64,
    parameter int NREG      = 32,
    parameter int IMMW      = 12,
    parameter int ILEN      = 32,
    parameter int RSV_LIMIT = 10,
    localparam int IDXW     = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mv_valid,
    input  logic [1:0]      mv_kind,
    input  logic [ILEN-1:0] mv_instr,
    input  logic [XLEN-1:0] mv_base_val,
    output logic            base_wr_en,
    output logic [IDXW-1:0] base_wr_idx,
    output logic [XLEN-1:0] base_wr_data,
    input  logic            ld_we,
    input  logic [IDXW-1:0] ld_idx,
    input  logic [XLEN-1:0] ld_data,
    input  logic [IDXW-1:0] rd_idx_a,
    output logic [XLEN-1:0] rd_data_a,
    output logic            rd_rsv_a,
    input  logic [IDXW-1:0] rd_idx_b,
    output logic [XLEN-1:0] rd_data_b,
    output logic            rd_rsv_b
);
    import xaddr_pkg::*;

    mv_kind_e        kind;
    logic [IMMW-1:0] f_imm;
    logic [IDXW-1:0] f_rs1;
    logic [IDXW-1:0] f_rd;
    logic [XLEN-1:0] regs [NREG];
    logic [XLEN-1:0] ext_src;
    logic [XLEN-1:0] add_src;
    logic [XLEN-1:0] sum;
    logic            ext_we;

    // Pull the instruction fields from their fixed positions.
    always_comb begin
        kind  = mv_kind_e'(mv_kind);
        f_imm = mv_instr[IMM_LSB +: IMMW];
        f_rs1 = mv_instr[RS1_LSB +: IDXW];
        f_rd  = mv_instr[RD_LSB  +: IDXW];
    end

    // Internal unrestricted read of the move source register.
    always_comb ext_src = regs[f_rs1];

    // Choose the add operand: base value for base-to-ext, else ext[rs1].
    always_comb add_src = (kind == MV_B2E) ? mv_base_val : ext_src;

    xaddr_addimm #(.XLEN(XLEN), .IMMW(IMMW)) u_add (
        .src_i (add_src),
        .imm_i (f_imm),
        .sum_o (sum)
    );

    // Route the sum to the base write request or the ext bank.
    always_comb begin
        base_wr_en   = mv_valid && (kind == MV_E2B);
        base_wr_idx  = f_rd;
        base_wr_data = sum;
        ext_we       = mv_valid && (kind == MV_B2E || kind == MV_E2E);
    end

    xaddr_bank #(.XLEN(XLEN), .NREG(NREG)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .mv_we_i   (ext_we),
        .mv_idx_i  (f_rd),
        .mv_data_i (sum),
        .ld_we_i   (ld_we),
        .ld_idx_i  (ld_idx),
        .ld_data_i (ld_data),
        .q_o       (regs)
    );

    xaddr_rdport #(.XLEN(XLEN), .NREG(NREG), .RSV_LIMIT(RSV_LIMIT)) u_rda (
        .regs_i (regs),
        .idx_i  (rd_idx_a),
        .data_o (rd_data_a),
        .rsv_o  (rd_rsv_a)
    );

    xaddr_rdport #(.XLEN(XLEN), .NREG(NREG), .RSV_LIMIT(RSV_LIMIT)) u_rdb (
        .regs_i (regs),
        .idx_i  (rd_idx_b),
        .data_o (rd_data_b),
        .rsv_o  (rd_rsv_b)
    );

    AST_E2B_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        base_wr_en |-> !ext_we); // R2
    AST_RD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_we && !ld_we) |=> ($stable(rd_idx_a) -> $stable(rd_data_a))); // R10
    AST_RD_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_we && !ext_we && 32'(ld_idx) >= RSV_LIMIT) |=>
        (rd_idx_a != $past(ld_idx) || rd_data_a == $past(ld_data))); // R8
endmodule

// File: tb/xaddr_regfile_tb.sv
module xaddr_regfile_tb;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        mv_valid = 0;
    logic [1:0]  mv_kind = 0;
    logic [31:0] mv_instr = 0;
    logic [63:0] mv_base_val = 0;
    logic        base_wr_en;
    logic [4:0]  base_wr_idx;
    logic [63:0] base_wr_data;
    logic        ld_we = 0;
    logic [4:0]  ld_idx = 0;
    logic [63:0] ld_data = 0;
    logic [4:0]  rd_idx_a = 10, rd_idx_b = 31;
    logic [63:0] rd_data_a, rd_data_b;
    logic        rd_rsv_a, rd_rsv_b;

    int total = 0, bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    xaddr_regfile u_dut (
        .clk(clk), .rst_n(rst_n), .mv_valid(mv_valid), .mv_kind(mv_kind),
        .mv_instr(mv_instr), .mv_base_val(mv_base_val), .base_wr_en(base_wr_en),
        .base_wr_idx(base_wr_idx), .base_wr_data(base_wr_data), .ld_we(ld_we),
        .ld_idx(ld_idx), .ld_data(ld_data), .rd_idx_a(rd_idx_a), .rd_data_a(rd_data_a),
        .rd_rsv_a(rd_rsv_a), .rd_idx_b(rd_idx_b), .rd_data_b(rd_data_b), .rd_rsv_b(rd_rsv_b)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Junk in funct3 and opcode bits, which must be ignored (R7).
    function automatic logic [31:0] ins(logic [11:0] imm, logic [4:0] rs1, logic [4:0] rd);
        return {imm, rs1, 3'b101, rd, 7'b1011011};
    endfunction

    task automatic step();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic move(logic [1:0] k, logic [11:0] imm, logic [4:0] rs1, logic [4:0] rd, logic [63:0] b);
        mv_valid = 1; mv_kind = k; mv_instr = ins(imm, rs1, rd); mv_base_val = b;
        step();
        mv_valid = 0; mv_kind = 0;
    endtask

    function automatic logic [63:0] peek_val(logic [4:0] idx);
        return 64'(idx);
    endfunction

    // Read any index (including reserved) through an ext-to-base move with imm 0.
    task automatic peek(logic [4:0] idx, output logic [63:0] v);
        mv_valid = 1; mv_kind = 2'b01; mv_instr = ins(12'h000, idx, 5'd1);
        #1 v = base_wr_data;
        mv_valid = 0; mv_kind = 0;
        #1;
    endtask

    task automatic t_reset();
        rd_idx_a = 10; rd_idx_b = 31; #1;
        check("R1 a", rd_data_a, 0);
        check("R1 b", rd_data_b, 0);
        check("R1 rsv", {62'd0, rd_rsv_a, rd_rsv_b}, 0);
    endtask

    task automatic t_b2e();
        move(2'b10, 12'h005, 5'd0, 5'd12, 64'h1000_0000_0000_0000);
        rd_idx_a = 12; #1;
        check("R3", rd_data_a, 64'h1000_0000_0000_0005);
        move(2'b10, 12'hFFF, 5'd0, 5'd13, 64'h100);
        rd_idx_a = 13; #1;
        check("R5 neg imm", rd_data_a, 64'hFF);
    endtask

    task automatic t_e2b();
        mv_valid = 1; mv_kind = 2'b01; mv_instr = ins(12'h003, 5'd12, 5'd7); #1;
        check("R2 en", 64'(base_wr_en), 1);
        check("R7 idx", 64'(base_wr_idx), 7);
        check("R2 data", base_wr_data, 64'h1000_0000_0000_0008);
        step(); mv_valid = 0; mv_kind = 0;
        rd_idx_a = 12; #1;
        check("R2 ext unchanged", rd_data_a, 64'h1000_0000_0000_0005);
    endtask

    task automatic t_e2e();
        move(2'b11, 12'h7FF, 5'd12, 5'd20, 0);
        rd_idx_b = 20; #1;
        check("R4", rd_data_b, 64'h1000_0000_0000_0804);
        move(2'b11, 12'h000, 5'd20, 5'd20, 0);
        #1 check("R5 zero imm self move R4", rd_data_b, 64'h1000_0000_0000_0804);
    endtask

    task automatic t_wrap();
        move(2'b10, 12'h002, 5'd0, 5'd14, 64'hFFFF_FFFF_FFFF_FFFF);
        rd_idx_a = 14; #1;
        check("R6", rd_data_a, 64'h1);
    endtask

    task automatic t_load();
        rd_idx_a = 15;
        ld_we = 1; ld_idx = 15; ld_data = 64'hDEAD_BEEF_0000_1234; #1;
        check("R10 old", rd_data_a, 0);
        step(); ld_we = 0; #1;
        check("R8", rd_data_a, 64'hDEAD_BEEF_0000_1234);
    endtask

    task automatic t_rsv();
        logic [63:0] v;
        ld_we = 1; ld_idx = 5; ld_data = 64'hABCD; step(); ld_we = 0;
        rd_idx_a = 5; rd_idx_b = 0; #1;
        check("R9 flag a", 64'(rd_rsv_a), 1);
        check("R9 zero a", rd_data_a, 0);
        check("R9 flag idx0", 64'(rd_rsv_b), 1);
        rd_idx_a = 9; rd_idx_b = 10; #1;
        check("R9 flag idx9", 64'(rd_rsv_a), 1);
        check("R9 no flag idx10", 64'(rd_rsv_b), 0);
        peek(5'd5, v);
        check("R9 storage kept", v, 64'hABCD);
    endtask

    task automatic t_conflict();
        mv_valid = 1; mv_kind = 2'b10; mv_instr = ins(12'h000, 5'd0, 5'd16); mv_base_val = 64'hAAAA;
        ld_we = 1; ld_idx = 16; ld_data = 64'hBBBB;
        step();
        mv_valid = 0; mv_kind = 0; ld_we = 0;
        rd_idx_a = 16; #1;
        check("R11", rd_data_a, 64'hAAAA);
    endtask

    task automatic t_idle();
        mv_valid = 1; mv_kind = 2'b00; mv_instr = ins(12'h001, 5'd0, 5'd12); mv_base_val = 64'h5; #1;
        check("R12 no base en", 64'(base_wr_en), 0);
        step();
        mv_valid = 0; mv_kind = 2'b10;
        step();
        mv_kind = 0;
        rd_idx_a = 12; #1;
        check("R12 ext unchanged", rd_data_a, 64'h1000_0000_0000_0005);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_b2e();
        t_e2b();
        t_e2e();
        t_wrap();
        t_load();
        t_rsv();
        t_conflict();
        t_idle();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule